// File: doc/BRIEF.md
# Ping-Pong Page Buffer Burst Read Sequencer

This block is a host-side controller that drives a multi-page synchronous burst block read on a flash device that has two internal page buffers. A single start pulse latches the caller's configuration. The block then programs the device over a request/acknowledge register bus, clears the device interrupt and issues the block-read command. After that it follows the device's interrupt handshake and drains one page buffer per signalled page, switching between the two buffers on each page.

The interrupt can come from a device pin or from polling a device register. In pin mode the pin passes through a two-stage synchronizer. No bus cycle is issued while the synchronized interrupt is low during a wait, so the flash chip enable stays released for the whole of that time. After the last page, a status read decides between success and failure. A per-wait cycle limit ends a stalled operation with a timeout code. Every word read from a buffer leaves on a valid-qualified output tagged with the buffer it came from.

Top module: `pprd_burst_seq`

## Requirements
- R1: After start, exactly seven writes are issued, in this order: 0xF100 = block address input, 0xF101 = buffer-select input, 0xF107 = page start word, 0xF104 = page count input, 0xF200 = buffer-control word, 0xF241 = 0x0000, 0xF220 = 0x000A.
- R2: The 0xF107 write always has bits 1:0 (start sector) cleared, whatever the input. The 0xF200 write is always 0x0800, which puts 4'b1000 in bits 11:8 (first buffer) and 2'b00 in bits 1:0 (buffer count).
- R3: Only one bus transaction is open at a time. While `bus_req` is high and `bus_ack` is low, the request, address, write flag and write data hold steady. Nothing is requested during reset.
- R4: The first buffer read happens only after the interrupt has been seen high following the command. In poll mode the interrupt is bit 15 of a read from 0xF241. In pin mode it is `int_pin` after two flip-flops.
- R5: Page k (counting from 0) is read from buffer k mod 2. Buffer 0 words are at 0x0200 + i and buffer 1 words are at 0x0600 + i, for i = 0..WORDS-1 in increasing order.
- R6: After the last word of a page, the next page is read only after the interrupt has been seen low and then high again.
- R7: `flash_ce` is high only while a bus transaction is open. In pin mode it stays low whenever the synchronized interrupt is low during an interrupt wait, and this holds after the command as well.
- R8: When `cont_mode` is 1, pin mode is used even if `poll_req` is 1, and 0xF241 is never read. Poll mode is used only when `poll_req` = 1 and `cont_mode` = 0.
- R9: The number of pages read equals the page count input, and a count of 0 reads one page.
- R10: After the last page, 0xF240 is read once. `done` then pulses for one cycle, with `err_code` = 1 if bit 10 of the status was 1 and `err_code` = 0 otherwise.
- R11: If an interrupt wait lasts TMO_CYC cycles, the operation ends with a one-cycle `done` and `err_code` = 2, with no status read, and the block returns to idle.
- R12: `rd_valid` pulses one cycle after each buffer-read acknowledge, with `rd_data` equal to the data acknowledged and `rd_buf` equal to the buffer index.
- R13: A start pulse while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle start pulse, taken only when idle |
| poll_req | input | 1 | 1 selects polling of the interrupt register |
| cont_mode | input | 1 | Unbounded block-read mode; forces the interrupt pin |
| blk_addr | input | 16 | Device and block address word |
| dbuf_sel | input | 16 | Buffer-select word |
| page_start | input | 16 | Start page word; the sector bits are forced to 0 |
| page_cnt | input | 16 | Number of pages (0 means one) |
| int_pin | input | 1 | Device interrupt pin (asynchronous) |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, valid with acknowledge |
| bus_ack | input | 1 | Bus acknowledge, ends the open transaction |
| flash_ce | output | 1 | Flash chip enable (active high) |
| rd_valid | output | 1 | Buffer word valid |
| rd_data | output | 16 | Buffer word |
| rd_buf | output | 1 | Buffer index of the word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 device failure, 2 timeout |

## Verification
The embedded properties watch the following on every cycle:
- the bus request and its fields hold steady until acknowledged;
- chip enable stays low during a pin-mode wait while the interrupt is low;
- the first buffer read follows an observed high interrupt;
- each data pulse traces back to a read acknowledge;
- `done` is a single-cycle pulse, and a timeout comes only from a wait state.

The bench scenarios are needed for the rest:
- the exact write order and values, including forced fields;
- the buffer alternation and address order;
- the low-then-high handshake between pages;
- the page count of zero, and the pin override in continuous mode;
- the status-driven result and the timeout window;
- a start pulse ignored mid-operation.

// File: rtl/pprd_pkg.sv
package pprd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CFG, ST_WRISE, ST_RDBUF, ST_WFALL, ST_STAT
  } pp_state_e;

  localparam logic [15:0] A_INT_REG  = 16'hF241;
  localparam logic [15:0] A_STAT_REG = 16'hF240;
  localparam logic [15:0] BUF0_BASE  = 16'h0200;
  localparam logic [15:0] BUF1_BASE  = 16'h0600;
  localparam logic [15:0] BUFCTL_WORD = 16'h0800;
  localparam logic [15:0] CMD_BLKRD  = 16'h000A;
  localparam logic [2:0]  CFG_LAST   = 3'd6;

  localparam logic [1:0] RES_OK   = 2'd0;
  localparam logic [1:0] RES_FAIL = 2'd1;
  localparam logic [1:0] RES_TMO  = 2'd2;

  function automatic logic [15:0] cfg_addr(input logic [2:0] i);
    case (i)
      3'd0:    cfg_addr = 16'hF100;
      3'd1:    cfg_addr = 16'hF101;
      3'd2:    cfg_addr = 16'hF107;
      3'd3:    cfg_addr = 16'hF104;
      3'd4:    cfg_addr = 16'hF200;
      3'd5:    cfg_addr = A_INT_REG;
      default: cfg_addr = 16'hF220;
    endcase
  endfunction

  function automatic logic [15:0] pages_needed(input logic [15:0] n);
    pages_needed = (n == 16'd0) ? 16'd1 : n;
  endfunction

  function automatic logic [15:0] buf_word_addr(input logic b, input logic [15:0] w);
    buf_word_addr = (b ? BUF1_BASE : BUF0_BASE) + w;
  endfunction

endpackage

// File: rtl/pprd_sync.sv
module pprd_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      lvl  <= 1'b0;
    end else begin
      meta <= din;
      lvl  <= meta;
    end
  end

  // R4
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl) |-> $past(din, 2));

endmodule

// File: rtl/pprd_tmo.sv
module pprd_tmo #(
  parameter int LIMIT = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (run && cnt != LIM)  cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);

  // R11
  tmo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && run && !clr) |=> expired);

endmodule

// File: rtl/pprd_burst_seq.sv
module pprd_burst_seq
  import pprd_pkg::*;
#(
  parameter int WORDS   = 8,
  parameter int TMO_CYC = 4000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        poll_req,
  input  logic        cont_mode,
  input  logic [15:0] blk_addr,
  input  logic [15:0] dbuf_sel,
  input  logic [15:0] page_start,
  input  logic [15:0] page_cnt,
  input  logic        int_pin,
  output logic        bus_req,
  output logic        bus_we,
  output logic [15:0] bus_addr,
  output logic [15:0] bus_wdata,
  input  logic [15:0] bus_rdata,
  input  logic        bus_ack,
  output logic        flash_ce,
  output logic        rd_valid,
  output logic [15:0] rd_data,
  output logic        rd_buf,
  output logic        busy,
  output logic        done,
  output logic [1:0]  err_code
);
  localparam int WW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [WW-1:0] LAST_WD = WW'(WORDS - 1);

  pp_state_e   st;
  logic [2:0]  idx;
  logic [15:0] blk_q, sel_q, ps_q, cnt_q, pg;
  logic [WW-1:0] wd;
  logic        pin_q;
  logic [15:0] cfg_word;

  // named internal events
  logic int_lvl, tmo_hit, in_wait, lvl_now, sample_ok;
  logic rise_evt, fall_evt, tmo_take, tmo_clr, last_page;

  pprd_sync u_sync (.clk(clk), .rst_n(rst_n), .din(int_pin), .lvl(int_lvl));

  assign in_wait   = (st == ST_WRISE) || (st == ST_WFALL);
  assign lvl_now   = pin_q ? int_lvl : bus_rdata[15];
  assign sample_ok = pin_q ? 1'b1 : bus_ack;
  assign rise_evt  = (st == ST_WRISE) && sample_ok && lvl_now;
  assign fall_evt  = (st == ST_WFALL) && sample_ok && !lvl_now;
  assign tmo_take  = in_wait && tmo_hit && !rise_evt && !fall_evt &&
                     (pin_q || bus_ack);
  assign tmo_clr   = !in_wait || rise_evt || fall_evt;
  assign last_page = (pg + 16'd1) == pages_needed(cnt_q);

  pprd_tmo #(.LIMIT(TMO_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr(tmo_clr), .run(in_wait), .expired(tmo_hit)
  );

  always_comb begin
    case (idx)
      3'd0:    cfg_word = blk_q;
      3'd1:    cfg_word = sel_q;
      3'd2:    cfg_word = ps_q & 16'hFFFC;
      3'd3:    cfg_word = cnt_q;
      3'd4:    cfg_word = BUFCTL_WORD;
      3'd5:    cfg_word = 16'h0000;
      default: cfg_word = CMD_BLKRD;
    endcase
  end

  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = 16'h0000;
    bus_wdata = 16'h0000;
    case (st)
      ST_CFG: begin
        bus_req = 1'b1; bus_we = 1'b1;
        bus_addr = cfg_addr(idx); bus_wdata = cfg_word;
      end
      ST_WRISE, ST_WFALL: begin
        bus_req  = !pin_q;
        bus_addr = pin_q ? 16'h0000 : A_INT_REG;
      end
      ST_RDBUF: begin
        bus_req = 1'b1; bus_addr = buf_word_addr(pg[0], 16'(wd));
      end
      ST_STAT: begin
        bus_req = 1'b1; bus_addr = A_STAT_REG;
      end
      default: ;
    endcase
  end

  assign flash_ce = bus_req;
  assign busy     = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; idx <= '0; pg <= '0; wd <= '0; pin_q <= 1'b1;
      blk_q <= '0; sel_q <= '0; ps_q <= '0; cnt_q <= '0;
      done <= 1'b0; err_code <= RES_OK;
      rd_valid <= 1'b0; rd_data <= '0; rd_buf <= 1'b0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          blk_q <= blk_addr; sel_q <= dbuf_sel; ps_q <= page_start; cnt_q <= page_cnt;
          pin_q <= cont_mode | ~poll_req;
          idx <= '0; pg <= '0; wd <= '0; err_code <= RES_OK;
          st <= ST_CFG;
        end
        ST_CFG: if (bus_ack) begin
          if (idx == CFG_LAST) st <= ST_WRISE;
          else                 idx <= idx + 3'd1;
        end
        ST_WRISE, ST_WFALL: begin
          if (rise_evt)      st <= ST_RDBUF;
          else if (fall_evt) st <= ST_WRISE;
          else if (tmo_take) begin
            st <= ST_IDLE; done <= 1'b1; err_code <= RES_TMO;
          end
        end
        ST_RDBUF: if (bus_ack) begin
          rd_valid <= 1'b1; rd_data <= bus_rdata; rd_buf <= pg[0];
          if (wd == LAST_WD) begin
            wd <= '0;
            if (last_page) st <= ST_STAT;
            else begin pg <= pg + 16'd1; st <= ST_WFALL; end
          end else wd <= wd + 1'b1;
        end
        ST_STAT: if (bus_ack) begin
          done <= 1'b1;
          err_code <= bus_rdata[10] ? RES_FAIL : RES_OK;
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  // R7
  ce_int_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && pin_q && !int_lvl) |-> !flash_ce);

  // R4
  read_after_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RDBUF && $past(st) == ST_WRISE) |->
      ($past(pin_q) ? $past(int_lvl) : $past(bus_ack && bus_rdata[15])));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  rdv_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_req && bus_ack && !bus_we));

  // R11
  tmo_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == RES_TMO) |-> $past(in_wait));

endmodule

// File: tb/pprd_burst_seq_bench.sv
module pprd_burst_seq_bench;
  localparam int W   = 4;
  localparam int TMO = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, poll_req = 1'b0, cont_mode = 1'b0;
  logic [15:0] blk_addr = '0, dbuf_sel = '0, page_start = '0, page_cnt = '0;
  logic int_pin = 1'b0;
  logic bus_req, bus_we, bus_ack = 1'b0;
  logic [15:0] bus_addr, bus_wdata, bus_rdata = '0;
  logic flash_ce, rd_valid, rd_buf, busy, done;
  logic [15:0] rd_data;
  logic [1:0] err_code;

  pprd_burst_seq #(.WORDS(W), .TMO_CYC(TMO)) u_pprd_burst_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .poll_req(poll_req), .cont_mode(cont_mode),
    .blk_addr(blk_addr), .dbuf_sel(dbuf_sel), .page_start(page_start), .page_cnt(page_cnt),
    .int_pin(int_pin), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .flash_ce(flash_ce),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_buf(rd_buf), .busy(busy), .done(done),
    .err_code(err_code));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  // device / slave state
  int lat = 0; bit fresh = 1; bit ready = 0; bit fail_bit = 0;
  int spg = 0, swd = 0, reads_done = 0, f241_rd = 0, f240_rd = 0, wr_n = 0;
  int buf_bad = 0, hold_bad = 0, ce_bad = 0, cmd_cyc = 0;
  bit cmd_seen = 0, cmd_seen_d = 0, pin_mode_exp = 1;
  logic [15:0] hold_a = '0;
  logic [15:0] wr_a [0:15];
  logic [15:0] wr_d [0:15];
  // output monitor state
  int mpg = 0, mwd = 0, rd_n = 0, rd_bad = 0, done_n = 0, done_cyc = 0;
  logic [1:0] done_err = '0;

  function automatic logic [15:0] base_of(input int b);
    return (b % 2 == 1) ? 16'h0600 : 16'h0200;
  endfunction
  function automatic logic [15:0] data_fn(input logic [15:0] a, input int p);
    return a ^ {p[7:0], 8'h5A} ^ 16'h3C00;
  endfunction
  function automatic int pages_of(input logic [15:0] n);
    return (n == 16'd0) ? 1 : int'(n);
  endfunction
  function automatic logic [15:0] exp_wa(input int i);
    logic [15:0] t [0:6] = '{16'hF100, 16'hF101, 16'hF107, 16'hF104, 16'hF200, 16'hF241, 16'hF220};
    return t[i];
  endfunction
  function automatic logic [15:0] exp_wd(input int i, input logic [15:0] b, s, p, c);
    case (i)
      0: return b;
      1: return s;
      2: return {p[15:2], 2'b00};
      3: return c;
      4: return 16'h0800;
      5: return 16'h0000;
      default: return 16'h000A;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic serve();
    if (bus_we) begin
      if (wr_n < 16) begin wr_a[wr_n] = bus_addr; wr_d[wr_n] = bus_wdata; end
      wr_n++;
      if (bus_addr == 16'hF241) begin int_pin = 1'b0; ready = 1'b0; end
      if (bus_addr == 16'hF220 && bus_wdata == 16'h000A) begin cmd_seen = 1; cmd_cyc = cyc; end
    end else if (bus_addr == 16'hF241) begin
      f241_rd++; bus_rdata = {int_pin, 15'h0};
    end else if (bus_addr == 16'hF240) begin
      f240_rd++; bus_rdata = fail_bit ? 16'h0400 : 16'h0000;
    end else begin
      if (bus_addr != base_of(spg) + 16'(swd) || !ready) buf_bad++;
      bus_rdata = data_fn(bus_addr, spg);
      swd++;
      if (swd == W) begin swd = 0; spg++; reads_done++; end
    end
  endtask

  // bus slave and chip-enable monitor
  initial forever begin
    @(negedge clk);
    if (pin_mode_exp && cmd_seen_d && !int_pin && flash_ce) ce_bad++; // R7
    cmd_seen_d = cmd_seen;
    if (bus_ack) begin bus_ack = 1'b0; fresh = 1; end
    if (bus_req) begin
      if (fresh) begin lat = $urandom % 3; fresh = 0; hold_a = bus_addr; end
      else if (bus_addr != hold_a) hold_bad++;
      if (lat == 0) begin bus_ack = 1'b1; serve(); end
      else lat--;
    end else fresh = 1;
  end

  // output monitor and watchdog
  initial forever begin
    @(negedge clk);
    cyc++;
    if (rd_valid) begin
      if (rd_buf !== 1'(mpg % 2) || rd_data !== data_fn(base_of(mpg) + 16'(mwd), mpg)) rd_bad++;
      rd_n++; mwd++;
      if (mwd == W) begin mwd = 0; mpg++; end
    end
    if (done) begin done_n++; done_err = err_code; done_cyc = cyc; end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic dev_run(input int npg, input bit hang);
    wait (cmd_seen);
    if (!hang) begin
      repeat (5 + $urandom % 20) @(negedge clk);
      int_pin = 1'b1; ready = 1'b1;
      for (int p = 1; p < npg; p++) begin
        wait (reads_done >= p);
        repeat (2 + $urandom % 8) @(negedge clk);
        int_pin = 1'b0; ready = 1'b0;
        repeat (4 + $urandom % 15) @(negedge clk);
        int_pin = 1'b1; ready = 1'b1;
      end
    end
  endtask

  task automatic run_op(input bit poll, input bit cont, input logic [15:0] b, s, p, c,
                        input bit fail, input bit hang, input bit restart);
    int npg = pages_of(c);
    @(negedge clk);
    spg = 0; swd = 0; reads_done = 0; f241_rd = 0; f240_rd = 0; wr_n = 0;
    buf_bad = 0; hold_bad = 0; ce_bad = 0; cmd_seen = 0; cmd_seen_d = 0;
    mpg = 0; mwd = 0; rd_n = 0; rd_bad = 0; done_n = 0;
    fail_bit = fail; pin_mode_exp = cont || !poll;
    poll_req = poll; cont_mode = cont; blk_addr = b; dbuf_sel = s; page_start = p; page_cnt = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fork
      dev_run(npg, hang);
      begin
        if (restart) begin
          wait (cmd_seen);
          repeat (3) @(negedge clk);
          start = 1'b1; @(negedge clk); start = 1'b0;
        end
      end
      begin
        int n = 0;
        while (done_n == 0 && n < 6000) begin @(negedge clk); n++; end
      end
    join
    repeat (4) @(negedge clk);
    chk(wr_n == 7, "R13 write count", wr_n, 7);
    for (int i = 0; i < 7; i++) begin
      chk(wr_a[i] == exp_wa(i), "R1 write addr", int'(wr_a[i]), int'(exp_wa(i)));
      chk(wr_d[i] == exp_wd(i, b, s, p, c), (i == 2 || i == 4) ? "R2 forced field" : "R1 write data",
          int'(wr_d[i]), int'(exp_wd(i, b, s, p, c)));
    end
    chk(hold_bad == 0, "R3 request hold", hold_bad, 0);
    chk(done_n == 1, "R10 done pulses", done_n, 1);
    chk(ce_bad == 0, "R7 ce while int low", ce_bad, 0);
    chk(!busy, "R11 back to idle", int'(busy), 0);
    if (hang) begin
      chk(done_err == 2'd2, "R11 timeout code", int'(done_err), 2);
      chk(f240_rd == 0, "R11 no status read", f240_rd, 0);
      chk(rd_n == 0, "R11 no data", rd_n, 0);
      chk(done_cyc - cmd_cyc >= TMO && done_cyc - cmd_cyc <= TMO + 12, "R11 timeout window",
          done_cyc - cmd_cyc, TMO);
    end else begin
      chk(rd_n == npg * W, "R9 words read", rd_n, npg * W);
      chk(rd_bad == 0, "R12 data and tag", rd_bad, 0);
      chk(buf_bad == 0, "R5 R6 buffer order and handshake", buf_bad, 0);
      chk(f240_rd == 1, "R10 status reads", f240_rd, 1);
      chk(done_err == (fail ? 2'd1 : 2'd0), "R10 result code", int'(done_err), fail ? 1 : 0);
    end
    if (pin_mode_exp) chk(f241_rd == 0, "R8 pin source", f241_rd, 0);
    else              chk(f241_rd > 0, "R4 polled source", f241_rd, 1);
  endtask

  initial begin
    void'($urandom(32'd17));
    repeat (3) @(negedge clk);
    chk(!bus_req, "R3 reset request", int'(bus_req), 0);
    chk(!flash_ce, "R7 reset ce", int'(flash_ce), 0);
    chk(!done && !busy && !rd_valid, "R10 reset outputs", int'({done, busy, rd_valid}), 0);
    rst_n = 1'b1;
    // directed corners
    run_op(1'b0, 1'b0, 16'h1234, 16'h0001, 16'h0041, 16'd3, 1'b0, 1'b0, 1'b0);
    run_op(1'b1, 1'b0, 16'h8001, 16'h0002, 16'h0007, 16'd4, 1'b1, 1'b0, 1'b0);
    run_op(1'b1, 1'b1, 16'h00FF, 16'h0000, 16'h0010, 16'd2, 1'b0, 1'b0, 1'b0);
    run_op(1'b0, 1'b0, 16'hABCD, 16'h0003, 16'hFFFF, 16'd0, 1'b0, 1'b0, 1'b0);
    run_op(1'b0, 1'b0, 16'h0101, 16'h0000, 16'h0020, 16'd2, 1'b0, 1'b1, 1'b0);
    run_op(1'b1, 1'b0, 16'h0202, 16'h0001, 16'h0022, 16'd1, 1'b0, 1'b1, 1'b0);
    run_op(1'b0, 1'b0, 16'h0303, 16'h0001, 16'h0031, 16'd3, 1'b0, 1'b0, 1'b1);
    // constrained random
    for (int k = 0; k < 8; k++) begin
      run_op(1'($urandom % 2), 1'($urandom % 2), 16'($urandom), 16'($urandom),
             16'($urandom), 16'($urandom % 5), 1'($urandom % 2), 1'b0, k == 3);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule